// File: doc/BRIEF.md
# Prescaled Match-Frequency Timer Counter

A 16-bit timer/counter with a small word-wide register interface. A clock prescaler with a fixed, uneven set of dividers produces count ticks. On each tick the counter steps up or down. In match-frequency mode the wrap point (TOP) comes from compare register 0. In normal mode TOP is the full 16-bit range. Each wrap sets a sticky overflow flag, which software clears by writing 1. The interrupt output is high while the flag is set and the overflow interrupt is enabled.

Changes to the enable bit and software-reset requests are not applied at once. They pass through a modelled two-cycle synchronisation delay. While a change is pending, a busy status bit is high. Software polls that bit before it reconfigures the timer. In one-shot mode the timer turns itself off after the first wrap.

Top module: `pmf_timer`

## Requirements
- R1: After the reset input, every register reads 0 (control, config, compare 0, interrupt enable, flag, busy, count) and `irq` is 0.
- R2: The control field bits 4:2 picks the prescaler divider. Values 0..7 select division by 1, 2, 4, 8, 16, 64, 256 and 1024. The prescaler is held at zero while the timer is off, so the first tick comes one full divider period after enable takes effect.
- R3: Count up is selected when config bit 0 is 0. On a tick where the count equals TOP, the counter goes to 0 and the overflow flag is set; on any other tick it increments. TOP is compare 0 (address 2) when config bit 2 is 1 (match-frequency mode), and 16'hFFFF when config bit 2 is 0.
- R4: Count down is selected when config bit 0 is 1. On a tick where the count is 0, the counter reloads TOP and the overflow flag is set; on any other tick it decrements.
- R5: With config bit 1 (one-shot) set, the first wrap also clears the enable bit. It reads back 0 at control bit 0 and counting stops. With config bit 1 clear, counting continues after a wrap.
- R6: The overflow flag (address 5, bit 0) is cleared by writing 1 to it. Writing 0 leaves it unchanged. A wrap in the same cycle as the clear write wins.
- R7: Writing 1 to bit 0 at address 3 enables the overflow interrupt, and writing 1 to bit 0 at address 4 disables it. Both addresses read the enable at bit 0. `irq` equals flag AND enable.
- R8: A control write (address 0) with bit 1 clear loads the prescaler field and the standby bit, and requests enable = bit 0. The enable busy bit (address 6, bit 0) is high for exactly 2 cycles, and then the new enable takes effect. Control writes are ignored while either busy bit is high.
- R9: A control write with bit 1 set starts a software reset. The reset busy bit (address 6, bit 1) is high for 2 cycles, and then every register returns to its R1 value. All writes are ignored while the reset is pending.
- R10: Address 7 reads the current count. Address 0 reads enable at bit 0, the prescaler field at bits 4:2 and the standby bit at bit 5. Address 1 reads direction, one-shot and mode at bits 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest cases to reach are the ones tied to slow events. One is the 1024 divider, where a wrap comes only after thousands of cycles. Another is a full-range wrap in normal mode, which takes 65536 ticks. The stimulus gets there by holding a long idle window while the bench's behavioural model is compared against the read port every cycle. Control and reset writes issued while a busy bit is still high are also exercised. These show that the write is dropped and the pending change still lands on time.

// File: rtl/pmf_timer.sv
module pmf_timer #(
  parameter int CW   = 16,
  parameter int PW   = 10,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  localparam int SW = $clog2(SYNC + 1);

  logic          enable, en_pend, stby, dir, oneshot, wave, ien, ovf;
  logic [2:0]    presc;
  logic [CW-1:0] cc0, count;
  logic [PW-1:0] psc, lim;
  logic [SW-1:0] en_cnt, rs_cnt;

  wire en_busy = en_cnt != '0;
  wire rs_busy = rs_cnt != '0;
  wire [CW-1:0] top = wave ? cc0 : {CW{1'b1}};

  always_comb begin
    case (presc)
      3'd0: lim = PW'(0);
      3'd1: lim = PW'(1);
      3'd2: lim = PW'(3);
      3'd3: lim = PW'(7);
      3'd4: lim = PW'(15);
      3'd5: lim = PW'(63);
      3'd6: lim = PW'(255);
      default: lim = PW'(1023);
    endcase
  end

  wire tick   = enable && psc == lim;
  wire at_end = dir ? (count == '0) : (count == top);
  wire wrap   = tick && at_end;
  wire wr_ok  = we && !rs_busy;
  wire ctrl_wr = wr_ok && addr == 3'd0 && !en_busy;
  wire clr_hit = wr_ok && addr == 3'd5 && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || rs_cnt == SW'(1)) begin
      enable <= 1'b0; en_pend <= 1'b0; stby <= 1'b0; presc <= '0;
      dir <= 1'b0; oneshot <= 1'b0; wave <= 1'b0; ien <= 1'b0;
      ovf <= 1'b0; cc0 <= '0; count <= '0; psc <= '0;
      en_cnt <= '0; rs_cnt <= '0;
    end else begin
      if (rs_busy) rs_cnt <= rs_cnt - SW'(1);
      if (en_busy) en_cnt <= en_cnt - SW'(1);

      if (en_cnt == SW'(1)) enable <= en_pend;
      else if (wrap && oneshot) enable <= 1'b0;

      if (!enable) psc <= '0;
      else psc <= tick ? '0 : psc + PW'(1);

      if (tick) begin
        if (dir) count <= at_end ? top : count - CW'(1);
        else     count <= at_end ? '0 : count + CW'(1);
      end

      if (wrap) ovf <= 1'b1;
      else if (clr_hit) ovf <= 1'b0;

      if (ctrl_wr) begin
        if (wdata[1]) rs_cnt <= SW'(SYNC);
        else begin
          en_pend <= wdata[0];
          presc   <= wdata[4:2];
          stby    <= wdata[5];
          en_cnt  <= SW'(SYNC);
        end
      end
      if (wr_ok) begin
        case (addr)
          3'd1: {wave, oneshot, dir} <= wdata[2:0];
          3'd2: cc0 <= wdata;
          3'd3: if (wdata[0]) ien <= 1'b1;
          3'd4: if (wdata[0]) ien <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: rdata[5:0] = {stby, presc, 1'b0, enable};
      3'd1: rdata[2:0] = {wave, oneshot, dir};
      3'd2: rdata = cc0;
      3'd3, 3'd4: rdata[0] = ien;
      3'd5: rdata[0] = ovf;
      3'd6: rdata[1:0] = {rs_busy, en_busy};
      default: rdata = count;
    endcase
  end

  assign irq = ovf & ien;

  assert_flag_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !wrap && !rs_busy) |=> !irq);
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[1]) |=> (en_busy && !$stable(en_cnt)));
  assert_en_apply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_busy) |-> (enable == en_pend || (oneshot && !enable)));
  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && oneshot && en_cnt != SW'(1) && rs_cnt != SW'(1)) |=> !enable);
  assert_ien_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == 3'd3 && wdata[0] && rs_cnt != SW'(1)) |=> ien);
  assert_swrst_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rs_busy) |-> (!enable && cc0 == '0 && count == '0 && !irq));
endmodule

// File: tb/sim_pmf_timer.sv
module sim_pmf_timer;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0] addr = 3'd7;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq;

  pmf_timer u0 (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr),
                .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;

  int m_en, m_pend, m_stby, m_presc, m_dir, m_os, m_wave, m_ien, m_ovf;
  int m_cc0, m_cnt, m_psc, m_ebc, m_rbc;

  task automatic m_defaults();
    m_en = 0; m_pend = 0; m_stby = 0; m_presc = 0; m_dir = 0; m_os = 0;
    m_wave = 0; m_ien = 0; m_ovf = 0; m_cc0 = 0; m_cnt = 0; m_psc = 0;
    m_ebc = 0; m_rbc = 0;
  endtask

  function automatic int mread(int a);
    case (a)
      0: return m_en + m_presc * 4 + m_stby * 32;
      1: return m_dir + m_os * 2 + m_wave * 4;
      2: return m_cc0;
      3, 4: return m_ien;
      5: return m_ovf;
      6: return (m_ebc != 0 ? 1 : 0) + (m_rbc != 0 ? 2 : 0);
      default: return m_cnt;
    endcase
  endfunction

  function automatic string rtag(int a);
    case (a)
      0: return "R10";
      1: return "R3";
      2: return "R3";
      3, 4: return "R7";
      5: return "R6";
      6: return "R8";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_defaults();
    else if (m_rbc == 1) m_defaults();
    else begin
      int sh, div, top, tk, wr, o_en, o_ebc, o_rbc, a, d;
      a = int'(addr); d = int'(wdata);
      sh = (m_presc <= 4) ? m_presc : 2 * m_presc - 4;
      div = 1 << sh;
      top = m_wave ? m_cc0 : 65535;
      tk = (m_en != 0 && m_psc == div - 1) ? 1 : 0;
      wr = (tk != 0 && (m_dir != 0 ? m_cnt == 0 : m_cnt == top)) ? 1 : 0;
      o_en = m_en; o_ebc = m_ebc; o_rbc = m_rbc;
      if (m_rbc > 0) m_rbc = m_rbc - 1;
      if (m_ebc > 0) m_ebc = m_ebc - 1;
      if (o_ebc == 1) m_en = m_pend;
      else if (wr != 0 && m_os != 0) m_en = 0;
      if (o_en == 0) m_psc = 0;
      else m_psc = tk != 0 ? 0 : m_psc + 1;
      if (tk != 0) begin
        if (m_dir != 0) m_cnt = (m_cnt == 0) ? top : m_cnt - 1;
        else m_cnt = (m_cnt == top) ? 0 : m_cnt + 1;
      end
      if (wr != 0) m_ovf = 1;
      else if (we && o_rbc == 0 && a == 5 && d[0]) m_ovf = 0;
      if (we && o_rbc == 0) begin
        case (a)
          0: if (o_ebc == 0) begin
               if (d[1]) m_rbc = 2;
               else begin
                 m_pend = d & 1; m_presc = (d >> 2) & 7; m_stby = (d >> 5) & 1;
                 m_ebc = 2;
               end
             end
          1: begin m_dir = d & 1; m_os = (d >> 1) & 1; m_wave = (d >> 2) & 1; end
          2: m_cc0 = d;
          3: if (d[0]) m_ien = 1;
          4: if (d[0]) m_ien = 0;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(rtag(int'(addr)), int'(rdata), mread(int'(addr)));
    chk("R7", int'(irq), (m_ovf != 0 && m_ien != 0) ? 1 : 0);
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1; we = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk); #1; we = 1'b0; addr = 3'd7; wdata = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rdchk(int a, string tag, int exp);
    @(negedge clk); #1; addr = 3'(a); #1;
    chk(tag, int'(rdata), exp);
    @(negedge clk); #1; addr = 3'd7;
  endtask

  task automatic ctrl(int d);
    wr(0, d); idle(3);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(2); #1; rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rdchk(a, "R1", 0);
    chk("R1", int'(irq), 0);

    wr(2, 3); wr(1, 4); wr(3, 1);
    wr(0, 1);
    rdchk(6, "R8", 1);
    idle(20);
    rdchk(0, "R8", 1);
    rdchk(5, "R3", 1);
    chk("R7", int'(irq), 1);

    wr(5, 0); rdchk(5, "R6", mread(5));
    wr(5, 1); rdchk(5, "R6", mread(5));
    wr(4, 1); idle(6); chk("R7", int'(irq), 0);
    wr(3, 1);

    ctrl(0);
    rdchk(7, "R2", mread(7));
    ctrl((2 << 2) | 1); idle(40);
    ctrl(0); wr(2, 1);
    ctrl((7 << 2) | 1 | 32); idle(4200);
    rdchk(0, "R10", mread(0));

    ctrl(0); wr(2, 5); wr(1, 5);
    ctrl(1); idle(20);
    rdchk(1, "R4", 5);

    ctrl(0); wr(1, 6); wr(5, 1);
    ctrl(1); idle(20);
    rdchk(0, "R5", 0);
    rdchk(5, "R5", 1);

    wr(1, 4); wr(0, 1); wr(0, 0); idle(3);
    rdchk(0, "R8", 1);

    ctrl(0); wr(1, 0); wr(5, 1);
    ctrl(1); idle(65545);
    rdchk(5, "R3", 1);

    wr(0, 2); wr(2, 9);
    rdchk(6, "R9", mread(6));
    idle(3);
    rdchk(2, "R9", 0);
    rdchk(0, "R9", 0);
    rdchk(7, "R9", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule